// File: doc/BRIEF.md
# PLL Lock Monitor with Feedback Watchdog

This block watches the reference clock and the feedback clock of a phase-locked loop and reports whether the loop is locked. Both clocks arrive as asynchronous inputs. A faster sampling clock synchronises them and detects their rising edges. At each feedback rising edge the block takes the number of sampling ticks since the latest reference rising edge as the phase difference. It compares that count with a programmable window to mark the feedback cycle as clean or erroneous.

The lock flag has hysteresis. A short run of erroneous cycles is enough to drop lock, while a much longer unbroken run of clean cycles is needed to declare it. A watchdog catches a feedback clock that stops altogether. It runs on a divided copy of the reference edges and is cleared by every feedback edge. If it expires while the flag is high, the flag falls. The outputs of this block are intended for a status pin or for the logic that sequences the PLL.

Top module: `pll_lock_monitor`

## Requirements
- R1: While `rst_n` is low, and right after it is released, `lock_o` is low and the block is unlocked with its error and clean runs empty.
- R2: The phase of a feedback cycle is the number of sampling ticks from the latest synchronised reference rising edge to the synchronised feedback rising edge. Coincident edges count as 0. The count saturates at all ones, which is also its value when no reference edge has been seen since reset. The cycle is erroneous when the phase is greater than `win_i` and clean when it is less than or equal to `win_i`.
- R3: While locked, `LOSS_N` (default 4) consecutive erroneous feedback cycles drive `lock_o` low. Fewer than `LOSS_N` leave it high.
- R4: While unlocked, `GAIN_N` (default 32) consecutive clean feedback cycles drive `lock_o` high. `GAIN_N`-1 clean cycles leave it low.
- R5: While locked, a clean feedback cycle empties the error run, so errors on the two sides of it do not add up.
- R6: While unlocked, an erroneous feedback cycle empties the clean run, so acquisition restarts from zero.
- R7: The watchdog advances once every `REF_DIV` synchronised reference rising edges and is cleared by every feedback edge. If it reaches `WD_LIMIT` while locked, `lock_o` falls. After that, a fresh run of `GAIN_N` clean cycles is needed to lock again.
- R8: `lock_o` changes only on the sampling-clock edge that follows a synchronised feedback rising edge or a watchdog expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| smp_clk | input | 1 | Sampling clock; all state is clocked by it |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_clk_i | input | 1 | Reference clock, asynchronous to `smp_clk` |
| fbk_clk_i | input | 1 | Feedback clock, asynchronous to `smp_clk` |
| win_i | input | PW | Largest phase in sampling ticks that still counts as clean |
| lock_o | output | 1 | High when locked, low while acquiring |

## Verification
The assertions assume that each clock input holds both its high and its low level for at least `SYNC_N`+1 sampling ticks, so that every rising edge is seen exactly once. They also assume that `win_i` holds still between feedback edges, and that feedback edges lag the reference edge they belong to by less than one reference period. The stimulus builds 16-tick reference periods with 8-tick halves. It places the feedback edge 0 to 7 ticks behind the reference edge, and it changes `win_i` only while reset is held. The window sweep repeats acquisition for every delay against several windows, so the equal and one-above boundaries are both covered.

// File: rtl/pll_lock_monitor.sv
module pll_lock_monitor #(
  parameter int PW       = 8,
  parameter int LOSS_N   = 4,
  parameter int GAIN_N   = 32,
  parameter int REF_DIV  = 64,
  parameter int WD_LIMIT = 8,
  parameter int SYNC_N   = 2
) (
  input  logic          smp_clk,
  input  logic          rst_n,
  input  logic          ref_clk_i,
  input  logic          fbk_clk_i,
  input  logic [PW-1:0] win_i,
  output logic          lock_o
);

  localparam int EW = $clog2(LOSS_N + 1);
  localparam int CW = $clog2(GAIN_N + 1);
  localparam int DW = (REF_DIV > 1) ? $clog2(REF_DIV) : 1;
  localparam int WW = $clog2(WD_LIMIT + 1);
  localparam logic [PW-1:0] PMAX = '1;

  logic [SYNC_N:0] ref_sh, fbk_sh;
  logic            ref_rise, fb_rise;
  logic [PW-1:0]   since_ref, phase;
  logic            err;
  logic [EW-1:0]   err_cnt;
  logic [CW-1:0]   clean_cnt;
  logic [DW-1:0]   div_cnt;
  logic            div_tick;
  logic [WW-1:0]   wd_cnt;
  logic            wd_fire;
  logic            lock_q;

  always_ff @(posedge smp_clk or negedge rst_n)
    if (!rst_n) begin
      ref_sh <= '0;
      fbk_sh <= '0;
    end else begin
      ref_sh <= {ref_sh[SYNC_N-1:0], ref_clk_i};
      fbk_sh <= {fbk_sh[SYNC_N-1:0], fbk_clk_i};
    end

  assign ref_rise = ref_sh[SYNC_N-1] & ~ref_sh[SYNC_N];
  assign fb_rise  = fbk_sh[SYNC_N-1] & ~fbk_sh[SYNC_N];

  always_ff @(posedge smp_clk or negedge rst_n)
    if (!rst_n)                 since_ref <= PMAX;
    else if (ref_rise)          since_ref <= PW'(1);
    else if (since_ref != PMAX) since_ref <= since_ref + 1'b1;

  assign phase = ref_rise ? '0 : since_ref;
  assign err   = phase > win_i;

  always_ff @(posedge smp_clk or negedge rst_n)
    if (!rst_n) div_cnt <= '0;
    else if (ref_rise) div_cnt <= div_tick ? '0 : div_cnt + 1'b1;

  assign div_tick = ref_rise && (div_cnt == DW'(REF_DIV - 1));

  always_ff @(posedge smp_clk or negedge rst_n)
    if (!rst_n)                                    wd_cnt <= '0;
    else if (fb_rise)                              wd_cnt <= '0;
    else if (div_tick && wd_cnt != WW'(WD_LIMIT))  wd_cnt <= wd_cnt + 1'b1;

  assign wd_fire = lock_q && !fb_rise && (wd_cnt == WW'(WD_LIMIT));

  always_ff @(posedge smp_clk or negedge rst_n)
    if (!rst_n) begin
      lock_q    <= 1'b0;
      err_cnt   <= '0;
      clean_cnt <= '0;
    end else if (wd_fire) begin
      lock_q    <= 1'b0;
      err_cnt   <= '0;
      clean_cnt <= '0;
    end else if (fb_rise) begin
      if (lock_q) begin
        clean_cnt <= '0;
        if (!err)                              err_cnt <= '0;
        else if (err_cnt == EW'(LOSS_N - 1)) begin
          lock_q  <= 1'b0;
          err_cnt <= '0;
        end else                               err_cnt <= err_cnt + 1'b1;
      end else begin
        err_cnt <= '0;
        if (err)                                 clean_cnt <= '0;
        else if (clean_cnt == CW'(GAIN_N - 1)) begin
          lock_q    <= 1'b1;
          clean_cnt <= '0;
        end else                                 clean_cnt <= clean_cnt + 1'b1;
      end
    end

  assign lock_o = lock_q;

  AST_ERR_RUN_BOUND: assert property (@(posedge smp_clk) disable iff (!rst_n) err_cnt < EW'(LOSS_N)); // R3
  AST_CLEAN_RUN_BOUND: assert property (@(posedge smp_clk) disable iff (!rst_n) clean_cnt < CW'(GAIN_N)); // R4
  AST_UNLOCKED_NO_ERR_RUN: assert property (@(posedge smp_clk) disable iff (!rst_n) !lock_q |-> err_cnt == '0); // R5
  AST_LOCKED_NO_CLEAN_RUN: assert property (@(posedge smp_clk) disable iff (!rst_n) lock_q |-> clean_cnt == '0); // R6
  AST_RISE_ON_CLEAN_EDGE: assert property (@(posedge smp_clk) disable iff (!rst_n) $rose(lock_q) |-> $past(fb_rise) && !$past(err)); // R4
  AST_FALL_HAS_CAUSE: assert property (@(posedge smp_clk) disable iff (!rst_n) $fell(lock_q) |-> ($past(fb_rise) && $past(err)) || $past(wd_fire)); // R8
  AST_WD_CLEARED_BY_FB: assert property (@(posedge smp_clk) disable iff (!rst_n) fb_rise |=> wd_cnt == '0); // R7
  AST_WD_DROPS_LOCK: assert property (@(posedge smp_clk) disable iff (!rst_n) wd_fire |=> !lock_q); // R7
  AST_QUIET_HOLDS_LOCK: assert property (@(posedge smp_clk) disable iff (!rst_n) !fb_rise && !wd_fire |=> $stable(lock_q)); // R8

endmodule

// File: tb/sim_pll_lock_monitor.sv
module sim_pll_lock_monitor;
  localparam int PW = 4;
  localparam int PER = 16;

  logic smp_clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_clk_i = 1'b0;
  logic fbk_clk_i = 1'b0;
  logic [PW-1:0] win_i = 4'd3;
  logic lock_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;

  always #2 smp_clk = ~smp_clk;

  pll_lock_monitor #(.PW(PW), .LOSS_N(4), .GAIN_N(32), .REF_DIV(2), .WD_LIMIT(3), .SYNC_N(2)) u0 (
    .smp_clk(smp_clk), .rst_n(rst_n), .ref_clk_i(ref_clk_i),
    .fbk_clk_i(fbk_clk_i), .win_i(win_i), .lock_o(lock_o));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: lock_o=%0d expected %0d", req, act, exp);
    end
  endtask

  // One reference period; feedback rises d ticks after the reference.
  task automatic period(input int d, input bit fb_on, input bit ref_on);
    for (int t = 0; t < PER; t++) begin
      @(negedge smp_clk);
      ref_clk_i = ref_on && (t < PER/2);
      fbk_clk_i = fb_on && (t >= d) && (t < d + PER/2);
    end
  endtask

  task automatic periods(input int n, input int d);
    for (int i = 0; i < n; i++) period(d, 1'b1, 1'b1);
  endtask

  task automatic do_reset(input int w);
    @(negedge smp_clk);
    rst_n = 1'b0;
    ref_clk_i = 1'b0;
    fbk_clk_i = 1'b0;
    win_i = PW'(w);
    repeat (4) @(negedge smp_clk);
    chk("R1 during reset", lock_o, 0);
    rst_n = 1'b1;
    @(negedge smp_clk);
    chk("R1 after release", lock_o, 0);
  endtask

  always @(posedge smp_clk) begin
    cyc++;
    if (cyc > 200000 && !done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: lock_o=%0d expected finish before cycle limit", lock_o);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset(3);
    // R4 acquisition threshold
    periods(31, 1);
    chk("R4 after 31 clean", lock_o, 0);
    periods(1, 1);
    chk("R4 after 32 clean", lock_o, 1);
    // R3 / R5 error runs while locked
    for (int i = 1; i <= 3; i++) begin
      periods(1, 6);
      chk("R3 short error run keeps lock", lock_o, 1);
    end
    periods(1, 2);
    chk("R5 clean cycle keeps lock", lock_o, 1);
    periods(3, 6);
    chk("R5 error run restarted", lock_o, 1);
    periods(1, 6);
    chk("R3 fourth error drops lock", lock_o, 0);
    // R6 error restarts acquisition
    periods(20, 0);
    periods(1, 7);
    periods(31, 3);
    chk("R6 clean run restarted", lock_o, 0);
    periods(1, 3);
    chk("R6 relock after full run", lock_o, 1);
    // R7 watchdog: expiry after 5 to 6 reference edges without feedback
    for (int i = 0; i < 4; i++) period(0, 1'b0, 1'b1);
    chk("R7 before watchdog expiry", lock_o, 1);
    for (int i = 0; i < 3; i++) period(0, 1'b0, 1'b1);
    chk("R7 watchdog expired", lock_o, 0);
    periods(31, 1);
    chk("R7 relock needs full run", lock_o, 0);
    periods(1, 1);
    chk("R7 relock after full run", lock_o, 1);
    periods(12, 1);
    chk("R7 feedback keeps watchdog quiet", lock_o, 1);
    // R2 no reference edge: phase saturates, every cycle erroneous
    do_reset(3);
    for (int i = 0; i < 32; i++) period(1, 1'b1, 1'b0);
    chk("R2 no reference never locks", lock_o, 0);
    // R2 window sweep: lock iff delay <= window
    for (int w = 0; w < 6; w++) begin
      for (int d = 0; d < 8; d++) begin
        do_reset(w);
        periods(32, d);
        chk("R2 window sweep", lock_o, (d <= w) ? 1 : 0);
      end
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule